// File: doc/BRIEF.md
# Interrupt and Wake-up Controller

This block collects three interrupt sources for a small 8-bit processor core: a timer overflow pulse, an external interrupt pin whose active edge software selects, and an input-change detector on an 8-bit port. Each source has a sticky flag that is set whenever its event occurs, whatever the enables say. Software reads and clears the flags through an 8-bit register bus. It arms the sources through an enable register that also holds a global enable.

The block drives one interrupt request to the instruction sequencer, together with the fixed vector address the sequencer jumps to. The sequencer pulses an accept input when it takes the interrupt, which clears the global enable. It pulses a return input on return-from-interrupt, which sets the global enable again. A separate wake-up output tells the sleep logic that an armed event is pending. This output ignores the global enable, so a core that sleeps with interrupts masked still wakes. The port-change detector compares the synchronised pins with a snapshot taken at the last port read. A per-bit mask register chooses which pins take part.

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset the enable register reads 8'h78, and the flag register and the wake mask register read 8'h00. `irqReq` and `wakeUp` are 0.
- R2: In the enable register (address 4'hE), bit 7 is the global enable, bit 2 arms the external pin, bit 1 arms the port change and bit 0 arms the timer. Bits 6..3 always read 1.
- R3: In the flag register (address 4'hF), bit 2 is the external pin flag, bit 1 is the port-change flag and bit 0 is the timer flag. Bits 7..3 read 0. A one-cycle `timerOvf` pulse sets bit 0 even when the timer source is not armed.
- R4: With `extEdgeSel`=1, a rising edge of the synchronised `extPin` sets flag bit 2. With `extEdgeSel`=0, a falling edge sets it. The opposite edge leaves the flag unchanged.
- R5: Flag bit 1 is set while any synchronised `portPins` bit whose wake mask bit is 1 differs from the snapshot. A `portRead` pulse loads the snapshot from the synchronised pins. A change on a pin whose mask bit is 0 leaves the flag unchanged.
- R6: A write to the flag register clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. An event in the same cycle as a clearing write leaves its flag set.
- R7: `irqReq` is 1 exactly when the global enable is 1 and some flag is 1 with its arm bit also 1.
- R8: An `intAccept` pulse clears the global enable. An `intReturn` pulse sets it. When both come in the same cycle, accept wins.
- R9: `wakeUp` is 1 exactly when some flag is 1 with its arm bit also 1, whatever the global enable is.
- R10: `irqVector` carries the hardware interrupt vector, 10'h008 by default.
- R11: The wake mask register (address 4'h9) reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 4 | Register address |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data, decoded from `busAddr` |
| portRead | input | 1 | Pulse when software reads the port; loads the change snapshot |
| timerOvf | input | 1 | One-cycle timer overflow pulse |
| extPin | input | 1 | External interrupt pin, asynchronous |
| extEdgeSel | input | 1 | 1 selects the rising edge of `extPin`, 0 the falling edge |
| portPins | input | 8 | Port input pins, asynchronous |
| intAccept | input | 1 | Sequencer took the interrupt |
| intReturn | input | 1 | Sequencer executed return-from-interrupt |
| irqReq | output | 1 | Interrupt request to the sequencer |
| wakeUp | output | 1 | Armed event pending, leave sleep |
| irqVector | output | 10 | Interrupt vector address |

## Verification
The bench builds the block with its default parameters: an 8-pin port and a two-stage synchroniser. With these values a settling window of five cycles follows every pin change, and all 256 mask patterns can be reached. Random mixes of pin changes, edge-select flips, snapshot loads, mask writes and flag clears show the level-type port-change flag setting again while a masked mismatch remains. Directed cases cover the opposite edge, an unmasked pin, a clear that meets a set in the same cycle, a simultaneous accept and return, and wake-up with the global enable off.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
  localparam int REG_W   = 8;
  localparam int SRC_N   = 3;
  localparam int SRC_TMR = 0;
  localparam int SRC_CHG = 1;
  localparam int SRC_EXT = 2;
  localparam int GIE_BIT = 7;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_ENABLE,
    RD_FLAG,
    RD_MASK
  } rdSel_e;

  typedef struct packed {
    logic   wrEnable;
    logic   wrFlag;
    logic   wrMask;
    logic   snapLoad;
    logic   accept;
    logic   retn;
    rdSel_e rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_wake_ctl.sv
module irq_wake_ctl
  import irq_wake_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 4'hE,
  parameter logic [ADDR_W-1:0] FLAG_ADDR   = 4'hF,
  parameter logic [ADDR_W-1:0] MASK_ADDR   = 4'h9
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              portRead,
  input  logic              intAccept,
  input  logic              intReturn,
  output ctlStrobe_t        strb
);
  logic hitEnable, hitFlag, hitMask;

  assign hitEnable = (busAddr == ENABLE_ADDR);
  assign hitFlag   = (busAddr == FLAG_ADDR);
  assign hitMask   = (busAddr == MASK_ADDR);

  always_comb begin
    strb          = '0;
    strb.wrEnable = busWe && hitEnable;
    strb.wrFlag   = busWe && hitFlag;
    strb.wrMask   = busWe && hitMask;
    strb.snapLoad = portRead;
    strb.accept   = intAccept;
    strb.retn     = intReturn;
    if (hitEnable)    strb.rdSel = RD_ENABLE;
    else if (hitFlag) strb.rdSel = RD_FLAG;
    else if (hitMask) strb.rdSel = RD_MASK;
    else              strb.rdSel = RD_NONE;
  end

  // at most one register write strobe per cycle
  always_comb begin
    a_one_write_r2: assert ($onehot0({strb.wrEnable, strb.wrFlag, strb.wrMask}))
      else $error("more than one register write decoded");
  end
endmodule

// File: rtl/irq_wake_dp.sv
module irq_wake_dp
  import irq_wake_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  logic [REG_W-1:0] busWdata,
  input  logic             timerOvf,
  input  logic             extPin,
  input  logic             extEdgeSel,
  input  logic [PORT_W-1:0] portPins,
  output logic [REG_W-1:0] busRdata,
  output logic             irqReq,
  output logic             wakeUp
);
  localparam int SYNC_W = PORT_W + 1;

  logic [SYNC_STAGES-1:0][SYNC_W-1:0] syncPipe;
  logic [SYNC_W-1:0] rawIn, syncOut;
  logic [PORT_W-1:0] portSync, portSnap, wakeMask;
  logic              extSync, extPrev, extEvt, chgEvt;
  logic              gie;
  logic [SRC_N-1:0]  armBits, flags, flagSet, flagNext, pending;

  assign rawIn = {extPin, portPins};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncPipe[s] <= '0;
        else       syncPipe[s] <= rawIn;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncPipe[s] <= '0;
        else       syncPipe[s] <= syncPipe[s-1];
    end
  end

  assign syncOut  = syncPipe[SYNC_STAGES-1];
  assign extSync  = syncOut[PORT_W];
  assign portSync = syncOut[PORT_W-1:0];

  // edge and change detection
  assign extEvt = extEdgeSel ? (extSync && !extPrev) : (!extSync && extPrev);
  assign chgEvt = |((portSync ^ portSnap) & wakeMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev  <= 1'b0;
      portSnap <= '0;
      wakeMask <= '0;
    end else begin
      extPrev <= extSync;
      if (strb.snapLoad) portSnap <= portSync;
      if (strb.wrMask)   wakeMask <= busWdata[PORT_W-1:0];
    end
  end

  // flags: written zeros clear, events always set
  always_comb begin
    flagSet          = '0;
    flagSet[SRC_TMR] = timerOvf;
    flagSet[SRC_CHG] = chgEvt;
    flagSet[SRC_EXT] = extEvt;
    flagNext = flags;
    if (strb.wrFlag) flagNext = flagNext & busWdata[SRC_N-1:0];
    flagNext = flagNext | flagSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags   <= '0;
      armBits <= '0;
      gie     <= 1'b0;
    end else begin
      flags <= flagNext;
      if (strb.wrEnable) armBits <= busWdata[SRC_N-1:0];
      if (strb.accept)        gie <= 1'b0;
      else if (strb.retn)     gie <= 1'b1;
      else if (strb.wrEnable) gie <= busWdata[GIE_BIT];
    end
  end

  assign pending = flags & armBits;
  assign wakeUp  = |pending;
  assign irqReq  = gie && wakeUp;

  always_comb begin
    case (strb.rdSel)
      RD_ENABLE: busRdata = {gie, {(REG_W-SRC_N-1){1'b1}}, armBits};
      RD_FLAG:   busRdata = REG_W'(flags);
      RD_MASK:   busRdata = REG_W'(wakeMask);
      default:   busRdata = '0;
    endcase
  end

  // ---------------- assertions ----------------
  p_timer_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    timerOvf |=> flags[SRC_TMR]);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrFlag |=> ((flags & $past(flags)) == $past(flags)));

  p_accept_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> !gie);

  p_return_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.retn && !strb.accept) |=> gie);

  p_irq_implies_wake_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> wakeUp);

  p_snap_clears_chg_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.snapLoad && !strb.wrMask && $stable(portSync)) |=> !chgEvt);
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
  import irq_wake_pkg::*;
#(
  parameter int                 PORT_W      = 8,
  parameter int                 SYNC_STAGES = 2,
  parameter int                 ADDR_W      = 4,
  parameter logic [ADDR_W-1:0]  ENABLE_ADDR = 4'hE,
  parameter logic [ADDR_W-1:0]  FLAG_ADDR   = 4'hF,
  parameter logic [ADDR_W-1:0]  MASK_ADDR   = 4'h9,
  parameter int                 VEC_W       = 10,
  parameter logic [VEC_W-1:0]   IRQ_VECTOR  = 10'h008
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              portRead,
  input  logic              timerOvf,
  input  logic              extPin,
  input  logic              extEdgeSel,
  input  logic [PORT_W-1:0] portPins,
  input  logic              intAccept,
  input  logic              intReturn,
  output logic              irqReq,
  output logic              wakeUp,
  output logic [VEC_W-1:0]  irqVector
);
  ctlStrobe_t strb;

  irq_wake_ctl #(
    .ADDR_W(ADDR_W), .ENABLE_ADDR(ENABLE_ADDR),
    .FLAG_ADDR(FLAG_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_ctl (
    .busWe(busWe), .busAddr(busAddr), .portRead(portRead),
    .intAccept(intAccept), .intReturn(intReturn), .strb(strb)
  );

  irq_wake_dp #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .timerOvf(timerOvf), .extPin(extPin), .extEdgeSel(extEdgeSel),
    .portPins(portPins), .busRdata(busRdata), .irqReq(irqReq),
    .wakeUp(wakeUp)
  );

  assign irqVector = IRQ_VECTOR;
endmodule

// File: tb/test_irq_wake_ctrl.sv
module test_irq_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PORT_W     = 8;
  localparam int SYNC       = 2;
  localparam int SETTLE     = SYNC + 3;
  localparam logic [3:0] A_EN = 4'hE, A_FL = 4'hF, A_MK = 4'h9;

  logic clk = 0, rstN = 0, busWe = 0, portRead = 0, timerOvf = 0;
  logic extPin = 0, extEdgeSel = 1, intAccept = 0, intReturn = 0;
  logic [3:0] busAddr = 0;
  logic [7:0] busWdata = 0, busRdata;
  logic [PORT_W-1:0] portPins = 0;
  logic irqReq, wakeUp;
  logic [9:0] irqVector;

  irq_wake_ctrl #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC)) i_irq_wake_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .portRead(portRead),
    .timerOvf(timerOvf), .extPin(extPin), .extEdgeSel(extEdgeSel),
    .portPins(portPins), .intAccept(intAccept), .intReturn(intReturn),
    .irqReq(irqReq), .wakeUp(wakeUp), .irqVector(irqVector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic gieM = 0, extM = 0, selM = 1;
  logic [2:0] enM = 0, flagM = 0;
  logic [7:0] maskM = 0, snapM = 0, pinsM = 0;

  function automatic logic [7:0] expEnable();
    return {gieM, 4'hF, enM};
  endfunction
  function automatic logic expWake();
    return |(flagM & enM);
  endfunction
  function automatic logic expIrq();
    return gieM && expWake();
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic readChk(string tag, logic [3:0] a, logic [7:0] exp, string what);
    @(negedge clk);
    busAddr = a;
    #1;
    check(tag, what, busRdata, exp);
  endtask

  task automatic checkAll(string tag);
    readChk(tag, A_EN, expEnable(), "enable reg (R2)");
    readChk(tag, A_FL, {5'b0, flagM}, "flag reg (R3)");
    readChk(tag, A_MK, maskM, "mask reg (R11)");
    check("R7", {tag, " irqReq"}, irqReq, expIrq());
    check("R9", {tag, " wakeUp"}, wakeUp, expWake());
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
    if (|((pinsM ^ snapM) & maskM)) flagM[1] = 1'b1;
  endtask

  task automatic busWrite(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 0;
  endtask

  task automatic opEnable(logic [7:0] v);
    busWrite(A_EN, v); gieM = v[7]; enM = v[2:0]; settle(); checkAll("R2");
  endtask
  task automatic opFlag(logic [7:0] v);
    busWrite(A_FL, v); flagM = flagM & v[2:0]; settle(); checkAll("R6");
  endtask
  task automatic opMask(logic [7:0] v);
    busWrite(A_MK, v); maskM = v; settle(); checkAll("R11");
  endtask
  task automatic opExt(logic v);
    @(negedge clk); extPin = v;
    if (v != extM && (v == selM)) flagM[2] = 1'b1;
    extM = v; settle(); checkAll("R4");
  endtask
  task automatic opSel(logic v);
    @(negedge clk); extEdgeSel = v; selM = v; settle(); checkAll("R4");
  endtask
  task automatic opPins(logic [7:0] v);
    @(negedge clk); portPins = v; pinsM = v; settle(); checkAll("R5");
  endtask
  task automatic opSnap();
    @(negedge clk); portRead = 1;
    @(negedge clk); portRead = 0;
    snapM = pinsM; settle(); checkAll("R5");
  endtask
  task automatic opTimer();
    @(negedge clk); timerOvf = 1;
    @(negedge clk); timerOvf = 0;
    flagM[0] = 1'b1; settle(); checkAll("R3");
  endtask
  task automatic opSeq(logic acc, logic ret);
    @(negedge clk); intAccept = acc; intReturn = ret;
    @(negedge clk); intAccept = 0; intReturn = 0;
    if (acc) gieM = 0; else if (ret) gieM = 1;
    settle(); checkAll("R8");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    readChk("R1", A_EN, 8'h78, "enable after reset");
    readChk("R1", A_FL, 8'h00, "flag after reset");
    readChk("R1", A_MK, 8'h00, "mask after reset");
    check("R1", "irqReq after reset", irqReq, 1'b0);
    check("R1", "wakeUp after reset", wakeUp, 1'b0);
    check("R10", "vector", irqVector, 10'h008);

    // R3: timer flag while unarmed; R9 wake without global enable
    opTimer();
    opEnable(8'h01);
    check("R9", "wake with gie off", wakeUp, 1'b1);
    check("R7", "no irq with gie off", irqReq, 1'b0);
    opSeq(1'b0, 1'b1);
    check("R7", "irq after return", irqReq, 1'b1);
    opSeq(1'b1, 1'b1);
    check("R8", "accept beats return", irqReq, 1'b0);

    // R6: clear and set in the same cycle, set wins
    @(negedge clk);
    busWe = 1; busAddr = A_FL; busWdata = 8'h00; timerOvf = 1;
    @(negedge clk);
    busWe = 0; timerOvf = 0;
    flagM = 3'b001; settle(); checkAll("R6");
    opFlag(8'h00);

    // R4: opposite edge ignored
    opSel(1'b1);
    opExt(1'b1);
    opFlag(8'h00);
    opExt(1'b0);
    check("R4", "falling edge ignored with rising select", busRdata, 8'h00);
    opSel(1'b0);
    opExt(1'b1);
    opExt(1'b0);

    // R5: unmasked change ignored, masked change flagged
    opFlag(8'h00);
    opMask(8'h0F);
    opPins(8'hF0);
    opPins(8'h01);
    opSnap();
    opFlag(8'h00);

    // random mix
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 9))
        0: opEnable(8'($urandom));
        1: opFlag(8'($urandom));
        2: opMask(8'($urandom));
        3: opExt(1'($urandom));
        4: opSel(1'($urandom));
        5: opPins(8'($urandom));
        6: opSnap();
        7: opTimer();
        8: opSeq(1'($urandom), 1'($urandom));
        default: opFlag(8'h00);
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule